// File: doc/BRIEF.md
# Zero-Page Indexed Address Sequencer

This block produces the effective address for the four zero-page indexed addressing modes of an 8-bit processor that has a 16-bit address bus. The mode is chosen by a 2-bit select. The block also receives the operand byte and both index registers, and it starts work on a one-cycle start strobe. The two direct modes add an index to the operand inside page zero and finish without touching memory. The two indirect modes fetch a two-byte pointer from page zero through a simple read port. The read port has a read strobe, an address, a data byte and an acknowledge.

Every zero-page sum and every step from the low pointer byte to the high pointer byte wraps inside page zero. A pointer that starts at 0x00FF therefore takes its high byte from 0x0000. In the post-indexed indirect mode, the Y register is added to the fetched 16-bit base as a full 16-bit addition. When the low-byte sum carries, the block spends one extra cycle adjusting the high byte, and it reports that extra cycle on a flag. The result is held on the effective-address output, and a one-cycle done pulse marks it as valid.

Top module: `zp_addr_seq`

## Requirements
- R1: Mode select 0 (zero page plus X) gives effective address {0x00, (operand + X) mod 256}. No read strobe is issued, and done is high in the cycle after the start strobe was sampled.
- R2: Mode select 1 (zero page plus Y) gives {0x00, (operand + Y) mod 256}. There are no reads, and done is high one cycle after start.
- R3: Mode select 2 (pre-indexed indirect) reads the pointer low byte at 0x00LL, where LL = (operand + X) mod 256. It then reads the high byte at 0x00((LL+1) mod 256). The effective address is {high, low}.
- R4: Pointer fetches never leave page zero. When the low pointer byte is at 0x00FF, the high byte is read from 0x0000. This holds in both indirect modes.
- R5: Mode select 3 (post-indexed indirect) reads the base low byte at {0x00, operand} and the high byte at {0x00, operand+1 mod 256}. The X register plays no part. The effective address is (base + Y) mod 65536.
- R6: In mode 3, when the base low byte plus Y is 256 or more, done comes one cycle later than without a carry. The extra-cycle flag is high while done is high.
- R7: In mode 3 without a carry, done is high in the cycle after the high pointer byte is accepted, and the extra-cycle flag is low. In every other mode the flag is low.
- R8: While the read strobe is high and acknowledge is low, the read strobe and bus address stay unchanged. Read data is taken on the clock edge where acknowledge is high.
- R9: A start strobe that arrives while a sequence is running is ignored, and the running sequence finishes with its own result.
- R10: Done is a single-cycle pulse.
- R11: After synchronous reset, done, read strobe, extra-cycle flag and effective address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sequence when the block is idle |
| mode | input | 2 | 0 zp+X, 1 zp+Y, 2 (zp+X) indirect, 3 (zp) indirect + Y |
| operand | input | 8 | Operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| rd_data | input | 8 | Read data from memory |
| ack | input | 1 | Memory acknowledge for the current read |
| bus_addr | output | 16 | Read address |
| rd_en | output | 1 | Read strobe |
| eff_addr | output | 16 | Effective address result |
| done | output | 1 | One-cycle result-valid pulse |
| extra_cycle | output | 1 | High when the post-index carry cycle was taken |

## Verification
The direct modes are tested with an operand and index pair whose sum overflows a byte, which separates wrapping from a carry into page one. They are also tested with distinct X and Y values, which shows which register was used. The indirect modes are run with pointers in the middle of page zero and at 0x00FF, so that a wrapped high-byte fetch can be told apart from a fetch at 0x0100. The post-indexed mode is run without a carry, with a carry, and with a carry out of 0xFF in the high byte, which separates the one-cycle path, the extra cycle and a full 16-bit sum. Slow acknowledges and a start strobe issued in the middle of a sequence show that the address is held during waits and that a busy block ignores the new request.

// File: rtl/zpa_pkg.sv
package zpa_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        AM_ZP_X     = 2'd0,
        AM_ZP_Y     = 2'd1,
        AM_PRE_IND  = 2'd2,
        AM_POST_IND = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_LO,
        S_PTR_HI,
        S_FIXUP,
        S_DONE
    } sstate_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } word_t;

    function automatic addr_t page0(input byte_t a);
        return {{BYTE_W{1'b0}}, a};
    endfunction
endpackage

// File: rtl/zpa_zp_sum.sv
// Zero-page location: the direct effective-address byte or the pointer slot.
module zpa_zp_sum
    import zpa_pkg::*;
(
    input  amode_e mode_i,
    input  byte_t  operand_i,
    input  byte_t  x_i,
    input  byte_t  y_i,
    output byte_t  loc_o
);
    always_comb begin
        case (mode_i)
            AM_ZP_X, AM_PRE_IND: loc_o = operand_i + x_i;   // byte width drops the carry
            AM_ZP_Y:             loc_o = operand_i + y_i;
            default:             loc_o = operand_i;
        endcase
    end
endmodule

// File: rtl/zpa_post_index.sv
// Low-byte addition of the post-index step, with carry out.
module zpa_post_index
    import zpa_pkg::*;
(
    input  byte_t base_lo_i,
    input  byte_t idx_i,
    output byte_t sum_lo_o,
    output logic  carry_o
);
    logic [BYTE_W:0] wide;
    assign wide     = {1'b0, base_lo_i} + {1'b0, idx_i};
    assign sum_lo_o = wide[BYTE_W-1:0];
    assign carry_o  = wide[BYTE_W];
endmodule

// File: rtl/zp_addr_seq.sv
module zp_addr_seq
    import zpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [BYTE_W-1:0] operand,
    input  logic [BYTE_W-1:0] idx_x,
    input  logic [BYTE_W-1:0] idx_y,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              done,
    output logic              extra_cycle
);
    amode_e  mode_in, mode_q;
    sstate_e st;
    byte_t   loc_d, loc_q, lo_q, y_q, sum_lo;
    logic    carry;
    word_t   ea_q;
    logic    extra_q;

    assign mode_in = amode_e'(mode);

    zpa_zp_sum u_zp_sum (
        .mode_i   (mode_in),
        .operand_i(operand),
        .x_i      (idx_x),
        .y_i      (idx_y),
        .loc_o    (loc_d)
    );

    zpa_post_index u_post_index (
        .base_lo_i(lo_q),
        .idx_i    (y_q),
        .sum_lo_o (sum_lo),
        .carry_o  (carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            mode_q  <= AM_ZP_X;
            loc_q   <= '0;
            lo_q    <= '0;
            y_q     <= '0;
            ea_q    <= '0;
            extra_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    mode_q  <= mode_in;
                    y_q     <= idx_y;
                    loc_q   <= loc_d;
                    extra_q <= 1'b0;
                    if (mode_in == AM_ZP_X || mode_in == AM_ZP_Y) begin
                        ea_q <= page0(loc_d);
                        st   <= S_DONE;
                    end else begin
                        st   <= S_PTR_LO;
                    end
                end
                S_PTR_LO: if (ack) begin
                    lo_q  <= rd_data;
                    loc_q <= loc_q + 1'b1;          // wraps inside page zero
                    st    <= S_PTR_HI;
                end
                S_PTR_HI: if (ack) begin
                    if (mode_q == AM_PRE_IND) begin
                        ea_q <= '{hi: rd_data, lo: lo_q};
                        st   <= S_DONE;
                    end else begin
                        ea_q <= '{hi: rd_data, lo: sum_lo};
                        if (carry) begin
                            extra_q <= 1'b1;
                            st      <= S_FIXUP;
                        end else begin
                            st      <= S_DONE;
                        end
                    end
                end
                S_FIXUP: begin
                    ea_q.hi <= ea_q.hi + 1'b1;
                    st      <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign rd_en       = (st == S_PTR_LO) || (st == S_PTR_HI);
    assign bus_addr    = rd_en ? page0(loc_q) : '0;
    assign eff_addr    = ea_q;
    assign done        = (st == S_DONE);
    assign extra_cycle = extra_q;

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !ack) |=> (rd_en && $stable(bus_addr)));

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_PTR_LO && ack) |=>
            (bus_addr == page0($past(bus_addr[BYTE_W-1:0]) + 8'd1)));

    // R6
    fixup_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_FIXUP) |=>
            (done && extra_cycle && eff_addr[ADDR_W-1:BYTE_W] ==
                $past(eff_addr[ADDR_W-1:BYTE_W]) + 8'd1));

    // R1
    direct_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && start && !mode[1]) |=> (done && !rd_en && !extra_cycle));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/test_zp_addr_seq.sv
module test_zp_addr_seq;
    logic        clk = 1'b0;
    logic        rst, start, ack;
    logic [1:0]  mode;
    logic [7:0]  operand, idx_x, idx_y, rd_data;
    logic [15:0] bus_addr, eff_addr;
    logic        rd_en, done, extra_cycle;

    int errors = 0;
    int checks = 0;

    logic [7:0]  zmem [256];
    int          lat_cfg = 0;
    int          wcnt = 0;
    int          rd_n = 0;
    logic [15:0] rd_log [4];
    bit          prev_wait = 0;
    logic [15:0] prev_addr = '0;

    always #4 clk = ~clk;   // 125 MHz

    zp_addr_seq i_zp_addr_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .operand(operand),
        .idx_x(idx_x), .idx_y(idx_y), .rd_data(rd_data), .ack(ack),
        .bus_addr(bus_addr), .rd_en(rd_en), .eff_addr(eff_addr),
        .done(done), .extra_cycle(extra_cycle)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // page-zero memory with programmable acknowledge latency
    always @(negedge clk) begin
        if (rd_en && prev_wait)
            chk(bus_addr == prev_addr, "R8", "address held during wait", bus_addr, prev_addr);
        prev_wait = 0;
        if (rd_en) begin
            if (wcnt >= lat_cfg) begin
                ack = 1'b1;
                rd_data = zmem[bus_addr[7:0]];
                wcnt = 0;
                if (rd_n < 4) rd_log[rd_n] = bus_addr;
                rd_n++;
            end else begin
                ack = 1'b0;
                wcnt++;
                prev_wait = 1;
                prev_addr = bus_addr;
            end
        end else begin
            ack = 1'b0;
            wcnt = 0;
        end
    end

    task automatic run(input string req, input logic [1:0] m, input logic [7:0] op,
                       input logic [7:0] x, input logic [7:0] y, input int lat,
                       input bit poke, input logic [15:0] exp_ea, input bit exp_extra,
                       input int exp_cyc, input int exp_nrd,
                       input logic [15:0] a0, input logic [15:0] a1);
        int cyc;
        lat_cfg = lat;
        rd_n = 0;
        @(negedge clk);
        mode = m; operand = op; idx_x = x; idx_y = y; start = 1'b1;
        @(negedge clk);
        cyc = 1;
        start = poke;
        if (poke) begin mode = 2'd0; operand = 8'h11; idx_x = 8'h22; end
        while (!done && cyc < 100) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        chk(done, req, "done seen", {31'd0, done}, 32'd1);
        chk(eff_addr == exp_ea, req, "effective address", eff_addr, exp_ea);
        chk(extra_cycle == exp_extra, req, "extra-cycle flag", extra_cycle, exp_extra);
        chk(cyc == exp_cyc, req, "cycles to done", cyc, exp_cyc);
        chk(rd_n == exp_nrd, req, "read count", rd_n, exp_nrd);
        if (exp_nrd == 2 && rd_n == 2) begin
            chk(rd_log[0] == a0, req, "low pointer address", rd_log[0], a0);
            chk(rd_log[1] == a1, req, "high pointer address", rd_log[1], a1);
        end
        @(negedge clk);
        chk(!done, "R10", "done falls after one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        chk(!done && !rd_en && !extra_cycle && eff_addr == 16'h0, "R11", "reset outputs",
            {eff_addr, 13'd0, done, rd_en, extra_cycle}, 32'd0);
    endtask

    task automatic t_direct;
        run("R1", 2'd0, 8'h80, 8'h90, 8'h07, 0, 0, 16'h0010, 0, 1, 0, 0, 0);
        run("R2", 2'd1, 8'h12, 8'h99, 8'h34, 0, 0, 16'h0046, 0, 1, 0, 0, 0);
    endtask

    task automatic t_pre_indexed;
        zmem[8'h24] = 8'h78; zmem[8'h25] = 8'h56;
        run("R3", 2'd2, 8'h20, 8'h04, 8'hEE, 0, 0, 16'h5678, 0, 3, 2, 16'h0024, 16'h0025);
        zmem[8'hFF] = 8'hCD; zmem[8'h00] = 8'hAB; zmem[8'h01] = 8'hEE;
        run("R4", 2'd2, 8'hF0, 8'h0F, 8'h00, 0, 0, 16'hABCD, 0, 3, 2, 16'h00FF, 16'h0000);
    endtask

    task automatic t_post_indexed;
        zmem[8'h40] = 8'h10; zmem[8'h41] = 8'h30;
        run("R7", 2'd3, 8'h40, 8'h33, 8'h05, 0, 0, 16'h3015, 0, 3, 2, 16'h0040, 16'h0041);
        zmem[8'h50] = 8'hF0; zmem[8'h51] = 8'h12;
        run("R6", 2'd3, 8'h50, 8'h00, 8'h20, 0, 0, 16'h1310, 1, 4, 2, 16'h0050, 16'h0051);
        run("R4", 2'd3, 8'hFF, 8'h00, 8'h01, 0, 0, 16'hABCE, 0, 3, 2, 16'h00FF, 16'h0000);
        zmem[8'h60] = 8'h80; zmem[8'h61] = 8'hFF;
        run("R5", 2'd3, 8'h60, 8'h01, 8'h90, 0, 0, 16'h0010, 1, 4, 2, 16'h0060, 16'h0061);
    endtask

    task automatic t_slow_ack;
        zmem[8'h70] = 8'h34; zmem[8'h71] = 8'h12;
        run("R8", 2'd2, 8'h6C, 8'h04, 8'h00, 2, 0, 16'h1234, 0, 7, 2, 16'h0070, 16'h0071);
    endtask

    task automatic t_busy_start;
        zmem[8'h80] = 8'hF8; zmem[8'h81] = 8'h01;
        run("R9", 2'd3, 8'h80, 8'h00, 8'h10, 1, 1, 16'h0208, 1, 6, 2, 16'h0080, 16'h0081);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) zmem[i] = 8'(i) ^ 8'h5A;
        rst = 1'b1; start = 1'b0; ack = 1'b0; rd_data = '0;
        mode = '0; operand = '0; idx_x = '0; idx_y = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_direct;
        t_pre_indexed;
        t_post_indexed;
        t_slow_ack;
        t_busy_start;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule